// File: doc/BRIEF.md
# Sixty-Four Line Interrupt Controller

The block gathers 64 interrupt lines into one processor interrupt request. Each line passes through a synchroniser, then through a per-line trigger stage. That stage either follows the line's level or latches a chosen edge into a pending flag. A line counts toward the request only while its enable bit is set. When several enabled lines are pending at once, an arbiter names one winner. It uses either fixed lowest-index priority or a rotating order in which the line last serviced drops to the bottom.

Software uses a simple register bus. It has a byte address, 32-bit write data, separate byte-write and word-write strobes, a read strobe and combinational read data. Each line has one control byte: bit 3 is the enable and bits 5:4 are the trigger code. Pending flags are seen through two status words, and edge flags are cleared by writing ones to them. Reading the winner register acts as servicing the winner, and this moves the rotation point.

A two-state machine produces the request. In ST_QUIET the output is low. The transition "raise" goes from ST_QUIET to ST_RAISED when any enabled line is pending. In ST_RAISED the output is high and the winner register holds a live index. The transition "drop" returns from ST_RAISED to ST_QUIET when no enabled line is pending. Otherwise each state holds.

Top module: `intc64`

## Requirements
- R1: After reset, irq_o is low, every control byte reads 0x00 (disabled, level-high), both status words read zero, and the winner register at 0x00 reads zero.
- R2: Control byte of line n is at address 0x40+n, word lane n mod 4 of the word at 0x40+4*(n/4) (lane 0 = bits 7:0). Only bit 3 (enable) and bits 5:4 (trigger: 00 level-high, 01 rising, 10 falling, 11 never pending) are stored; other bits read zero. A byte write changes only its own lane.
- R3: A level-high line's status bit follows the synchronised input, and writing 1 to that status bit has no effect.
- R4: A rising-edge line sets its status bit on a 0-to-1 input change and keeps it after the input returns low.
- R5: A falling-edge line sets its status bit on a 1-to-0 input change and ignores a 0-to-1 change.
- R6: Writing a word to a status register clears each edge-latched bit written with 1; bits written with 0 stay set.
- R7: irq_o is high only while some line is both pending and enabled. A pending but disabled line is visible in status but does not raise irq_o.
- R8: The word at 0x00 reads bit 31 equal to irq_o and bits 5:0 as the winning line. With rotation off, the lowest pending enabled index wins.
- R9: Bit 6 of the word at 0x20 turns rotation on and reads back. With rotation on, a read of 0x00 while irq_o is high makes that winner lowest priority, and the search then starts at the next index up, wrapping past 63 to 0.
- R10: The status word at 0x80 holds lines 0 to 31 and the word at 0x84 holds lines 32 to 63, with bit n mod 32 for line n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt lines, asynchronous |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data; byte writes use bits 7:0 |
| bus_wr_byte | input | 1 | Write one byte at bus_addr |
| bus_wr_word | input | 1 | Write the word at bus_addr[7:2] |
| bus_rd | input | 1 | Read strobe; at 0x00 it services the winner |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A stuck or wrongly set edge flag shows up in the status word and on irq_o within about four cycles of the input change or the clearing write. The bench looks for it there after every stimulus. A broken state register or winner register shows as bit 31 of the winner word disagreeing with irq_o, or as a wrong index. If the rotation point is wrong, the second read in a rotation sequence names the wrong line. The sequence 10, 40, 3, 10 exposes that on the next read after the bad update.

// File: rtl/intc64_pkg.sv
package intc64_pkg;
    localparam int N_SRC    = 64;
    localparam int IDX_W    = $clog2(N_SRC);
    localparam int EN_BIT   = 3;
    localparam int TRIG_LSB = 4;
    localparam int ROT_BIT  = 6;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_NONE = 2'b11
    } trig_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/intc64_src.sv
module intc64_src
    import intc64_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din,
    input  trig_e trig,
    input  logic  clr,
    output logic  pend
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic prev_q, edge_q;
    logic lvl, is_edge, hit;

    assign lvl     = sync_q[SYNC_STAGES-1];
    assign is_edge = (trig == TRIG_RISE) || (trig == TRIG_FALL);
    assign hit     = ((trig == TRIG_RISE) && lvl && !prev_q) ||
                     ((trig == TRIG_FALL) && !lvl && prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            prev_q <= lvl;
            if (!is_edge)  edge_q <= 1'b0;
            else if (hit)  edge_q <= 1'b1;
            else if (clr)  edge_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (trig)
            TRIG_HIGH: pend = lvl;
            TRIG_RISE,
            TRIG_FALL: pend = edge_q;
            default:   pend = 1'b0;
        endcase
    end

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && edge_q && !clr) |=> (edge_q || !is_edge)); // R4
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && clr && !hit) |=> !edge_q); // R6
endmodule

// File: rtl/intc64_arb.sv
module intc64_arb
    import intc64_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] active,
    input  logic             rotate,
    input  logic             svc,
    output logic             irq,
    output logic [IDX_W-1:0] win
);
    localparam logic [N_SRC-1:0] ONE = 1;

    irq_state_e state_q, state_d;
    logic [IDX_W-1:0] last_q, win_q, pick, base, idx;
    logic any;
    logic [N_SRC-1:0] act_q;

    always_comb begin
        any  = |active;
        base = rotate ? last_q + 1'b1 : '0;
        pick = '0;
        idx  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            idx = base + IDX_W'(i);
            if (active[idx]) pick = idx;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (any)  state_d = ST_RAISED;
            ST_RAISED: if (!any) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            win_q   <= '0;
            last_q  <= '1;
            act_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= pick;
            act_q   <= active;
            if (svc && state_q == ST_RAISED) last_q <= win_q;
        end
    end

    always_comb begin
        irq = (state_q == ST_RAISED);
        win = win_q;
    end

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (act_q != '0)); // R7
    AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> act_q[win_q]); // R8
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(!rotate)) |-> ((act_q & ((ONE << win_q) - ONE)) == '0)); // R8
endmodule

// File: rtl/intc64_regs.sv
module intc64_regs
    import intc64_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [7:0]            addr,
    input  logic [31:0]           wdata,
    input  logic                  wr_byte,
    input  logic                  wr_word,
    input  logic [N_SRC-1:0]      pend,
    input  logic                  irq,
    input  logic [IDX_W-1:0]      win,
    output logic [31:0]           rdata,
    output logic [N_SRC-1:0]      en,
    output logic [N_SRC-1:0][1:0] trig,
    output logic                  rotate,
    output logic [N_SRC-1:0]      clr
);
    logic [N_SRC-1:0]      en_q;
    logic [N_SRC-1:0][1:0] trg_q;
    logic                  rot_q;
    logic [5:0]            word;
    logic [31:0]           wd;
    logic [3:0]            wsel;

    assign word = addr[7:2];
    assign wd   = wr_byte && !wr_word ? {4{wdata[7:0]}} : wdata;
    assign wsel = wr_word ? 4'hF : (wr_byte ? (4'b0001 << addr[1:0]) : 4'h0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            trg_q <= '0;
            rot_q <= 1'b0;
        end else begin
            if (wsel[0] && word == 6'd8) rot_q <= wd[ROT_BIT];
            for (int s = 0; s < N_SRC; s++) begin
                if (wsel[s % 4] && word == 6'(16 + s / 4)) begin
                    en_q[s]  <= wd[8 * (s % 4) + EN_BIT];
                    trg_q[s] <= wd[8 * (s % 4) + TRIG_LSB +: 2];
                end
            end
        end
    end

    always_comb begin
        for (int s = 0; s < N_SRC; s++)
            clr[s] = (word == 6'(32 + s / 32)) && wsel[(s % 32) / 8] && wd[s % 32];
    end

    always_comb begin
        rdata = '0;
        case (word)
            6'd0:  begin
                rdata[31]        = irq;
                rdata[IDX_W-1:0] = win;
            end
            6'd8:  rdata[ROT_BIT] = rot_q;
            6'd32: rdata = pend[31:0];
            6'd33: rdata = pend[63:32];
            default: begin
                if (word[5:4] == 2'b01) begin
                    for (int k = 0; k < 4; k++) begin
                        rdata[8 * k + EN_BIT]         = en_q[{word[3:0], 2'(k)}];
                        rdata[8 * k + TRIG_LSB +: 2]  = trg_q[{word[3:0], 2'(k)}];
                    end
                end
            end
        endcase
    end

    assign en     = en_q;
    assign trig   = trg_q;
    assign rotate = rot_q;
endmodule

// File: rtl/intc64.sv
module intc64
    import intc64_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] src_i,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_wr_byte,
    input  logic        bus_wr_word,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    logic [N_SRC-1:0]      pend, en, clr;
    logic [N_SRC-1:0][1:0] trig_w;
    logic                  rotate, irq;
    logic [IDX_W-1:0]      win;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        intc64_src #(.SYNC_STAGES(SYNC_STAGES)) i_src (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (src_i[s]),
            .trig (trig_e'(trig_w[s])),
            .clr  (clr[s]),
            .pend (pend[s])
        );
    end

    intc64_regs i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .wr_byte(bus_wr_byte),
        .wr_word(bus_wr_word),
        .pend   (pend),
        .irq    (irq),
        .win    (win),
        .rdata  (bus_rdata),
        .en     (en),
        .trig   (trig_w),
        .rotate (rotate),
        .clr    (clr)
    );

    intc64_arb i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .active(pend & en),
        .rotate(rotate),
        .svc   (bus_rd && bus_addr == 8'h00),
        .irq   (irq),
        .win   (win)
    );

    assign irq_o = irq;
endmodule

// File: tb/test_intc64.sv
`timescale 1ns/1ps
module test_intc64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr_byte = 1'b0;
    logic        bus_wr_word = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    intc64 i_intc64 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr_byte(bus_wr_byte), .bus_wr_word(bus_wr_word),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_word(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_word = 1'b1;
        @(negedge clk);
        bus_wr_word = 1'b0;
    endtask

    task automatic wr_byte(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = {24'h0, d}; bus_wr_byte = 1'b1;
        @(negedge clk);
        bus_wr_byte = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #0.5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'h0, irq_o}, 32'h0);
        rd(8'h40, v); check("R1 ctl", v, 32'h0);
        rd(8'h7C, v); check("R1 ctl hi", v, 32'h0);
        rd(8'h80, v); check("R1 sts0", v, 32'h0);
        rd(8'h84, v); check("R1 sts1", v, 32'h0);
        rd(8'h00, v); check("R1 win", v, 32'h0);
    endtask

    task automatic t_ctl_rw();
        logic [31:0] v;
        wr_word(8'h44, 32'hFF1828CF);
        rd(8'h44, v); check("R2 word write", v, 32'h38182808);
        wr_byte(8'h47, 8'h00);
        rd(8'h44, v); check("R2 byte lane", v, 32'h00182808);
        wr_word(8'h44, 32'h0);
        rd(8'h44, v); check("R2 cleared", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr_byte(8'h42, 8'h08);
        src_i[2] = 1'b1; cycles(6);
        rd(8'h80, v); check("R3 follows high", v, 32'h4);
        check("R3 irq", {31'h0, irq_o}, 32'h1);
        wr_word(8'h80, 32'h4); cycles(3);
        rd(8'h80, v); check("R3 w1c no effect", v, 32'h4);
        src_i[2] = 1'b0; cycles(6);
        rd(8'h80, v); check("R3 follows low", v, 32'h0);
        check("R3 irq low", {31'h0, irq_o}, 32'h0);
        wr_byte(8'h42, 8'h00);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr_byte(8'h61, 8'h18);
        src_i[33] = 1'b1; cycles(6);
        rd(8'h84, v); check("R10 sts1 bit", v, 32'h2);
        rd(8'h80, v); check("R10 sts0 empty", v, 32'h0);
        rd(8'h00, v); check("R8 winner 33", v, 32'h80000021);
        src_i[33] = 1'b0; cycles(6);
        rd(8'h84, v); check("R4 held", v, 32'h2);
        wr_word(8'h84, 32'h0); cycles(3);
        rd(8'h84, v); check("R6 zero keeps", v, 32'h2);
        wr_word(8'h84, 32'h2); cycles(3);
        rd(8'h84, v); check("R6 one clears", v, 32'h0);
        check("R7 irq drop", {31'h0, irq_o}, 32'h0);
        wr_byte(8'h61, 8'h00);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr_byte(8'h4C, 8'h28);
        src_i[12] = 1'b1; cycles(6);
        rd(8'h80, v); check("R5 rise ignored", v, 32'h0);
        src_i[12] = 1'b0; cycles(6);
        rd(8'h80, v); check("R5 fall latched", v, 32'h1000);
        check("R5 irq", {31'h0, irq_o}, 32'h1);
        wr_word(8'h80, 32'h1000); cycles(3);
        rd(8'h80, v); check("R6 fall cleared", v, 32'h0);
        wr_byte(8'h4C, 8'h00);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        src_i[20] = 1'b1; cycles(6);
        rd(8'h80, v); check("R7 pending visible", v, 32'h100000);
        check("R7 disabled no irq", {31'h0, irq_o}, 32'h0);
        wr_byte(8'h54, 8'h08); cycles(3);
        check("R7 enabled irq", {31'h0, irq_o}, 32'h1);
        wr_byte(8'h54, 8'h00); cycles(3);
        check("R7 disabled again", {31'h0, irq_o}, 32'h0);
        src_i[20] = 1'b0; cycles(6);
    endtask

    task automatic t_fixed();
        logic [31:0] v;
        wr_byte(8'h43, 8'h08);
        wr_byte(8'h4A, 8'h08);
        wr_byte(8'h68, 8'h08);
        src_i[3] = 1'b1; src_i[10] = 1'b1; src_i[40] = 1'b1; cycles(6);
        rd(8'h00, v); check("R8 lowest wins", v, 32'h80000003);
        cycles(1);
        rd(8'h00, v); check("R8 fixed stays", v, 32'h80000003);
        cycles(1);
    endtask

    task automatic t_rotate();
        logic [31:0] v;
        wr_word(8'h20, 32'h40);
        rd(8'h20, v); check("R9 cfg readback", v, 32'h40);
        cycles(1);
        rd(8'h00, v); check("R9 rot first", v, 32'h8000000A);
        cycles(1);
        rd(8'h00, v); check("R9 rot second", v, 32'h80000028);
        cycles(1);
        rd(8'h00, v); check("R9 rot wrap", v, 32'h80000003);
        cycles(1);
        rd(8'h00, v); check("R9 rot again", v, 32'h8000000A);
        wr_word(8'h20, 32'h0); cycles(2);
        rd(8'h00, v); check("R8 rotation off", v, 32'h80000003);
        src_i = '0; cycles(6);
        check("R7 all low", {31'h0, irq_o}, 32'h0);
    endtask

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_ctl_rw();
        t_level();
        t_rise();
        t_fall();
        t_enable();
        t_fixed();
        t_rotate();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule